// File: doc/BRIEF.md
# Exception Vector Address Generator

This block works out, in one combinational step, where the processor goes and what it records when an exception is taken. The exception-ordering logic has already chosen the winning exception and presents its 5-bit code, a flag telling a TLB refill (no matching entry) apart from other TLB faults, and the resume PC. The block also sees the status flags that steer vector selection: the boot-vector flag, the exception-level flag and the two extended-addressing enables. It then returns the handler PC, the EPC value with its write enable, the updated cause register and a strobe that moves the status register into exception level.

There are two vector bases. While the boot-vector flag is set, the base sits 0x200 above a boot-time base. While it is clear, the base is the programmable exception base with its low page bits forced to zero. Cache errors are the one exception to this. Their handler normally has to run from the uncached kernel window, so when the boot-vector flag is clear the base is rebuilt inside that window. The programmable base is used instead only when segmentation control is present and the override for the cache-error vector is enabled. The handler offset is 0x100 for a cache error and 0x180 for a general exception. A TLB refill takes 0x080 or 0x000, decided by the two top bits of the bad virtual address together with the user and kernel extended-addressing enables.

Top module: `exc_vec_gen`

## Requirements
- R1: When the boot-vector flag `boot_vec` is 1, the base is `boot_base + 0x200`, whatever the exception code, and `handler_pc` is that base plus the selected offset.
- R2: When `boot_vec` is 0 and the exception is not a cache error under forced-window rules (R4), the base is `ebase` with bits [11:0] cleared, and `handler_pc` is that base plus the offset.
- R3: Exception code 30 (cache error) always selects offset 0x100 and writes code 30 into the cause field, whether `boot_vec` is 0 or 1.
- R4: For code 30 with `boot_vec` 0, unless both `segctl_en` and `cerr_vec_ovr` are 1, the base is 0xA0000000 sign-extended to the address width, ORed with `ebase` bits [28:12].
- R5: With `tlb_refill` 1 and code 2 (load) or 3 (store), the offset is 0x080 when (`badva_region` != 0 or `ux`) and (`badva_region` != 3 or `kx`), and 0x000 otherwise.
- R6: Every other case uses offset 0x180. This includes codes 2 and 3 when `tlb_refill` is 0.
- R7: `epc_we` is 1 only when `exc_take` is 1 and `exl` is 0. `epc_next` always equals `resume_pc`.
- R8: `cause_next` equals `cause_in`, except that bits [6:2] hold `exc_code`.
- R9: `set_exl` equals `exc_take`. With `exc_take` 0, both `epc_we` and `set_exl` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exc_take | input | 1 | An exception is being taken this cycle |
| exc_code | input | 5 | Code of the winning exception |
| tlb_refill | input | 1 | TLB fault is a refill (no matching entry) |
| resume_pc | input | XLEN | PC at which execution resumes after the handler |
| boot_vec | input | 1 | Boot-vector flag from status |
| exl | input | 1 | Exception-level flag from status |
| ebase | input | XLEN | Programmable exception base |
| boot_base | input | XLEN | Boot-time exception base |
| segctl_en | input | 1 | Segmentation control present |
| cerr_vec_ovr | input | 1 | Cache-error vector override enabled |
| badva_region | input | 2 | Bad virtual address bits [63:62] |
| ux | input | 1 | User extended-addressing enable |
| kx | input | 1 | Kernel extended-addressing enable |
| cause_in | input | CAUSE_W | Current cause register |
| handler_pc | output | XLEN | Handler entry PC |
| epc_next | output | XLEN | Value for EPC |
| epc_we | output | 1 | EPC write enable |
| cause_next | output | CAUSE_W | Updated cause register |
| set_exl | output | 1 | Put status into exception level |

## Verification
The bench builds the block with a 64-bit address width and a 32-bit cause register, which are the defaults. At that width the sign extension of the uncached window shows up in the upper 32 bits of `handler_pc`. All four region values of the refill rule can be reached, and carries from the offset addition into the higher base bits can be seen. Random bases with nonzero low bits show that the alignment mask and the field mask of the forced window are both applied.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;
  localparam int CODE_W = 5;
  localparam logic [CODE_W-1:0] EC_TLB_LOAD  = 5'd2;
  localparam logic [CODE_W-1:0] EC_TLB_STORE = 5'd3;
  localparam logic [CODE_W-1:0] EC_CACHE_ERR = 5'd30;

  localparam int OFF_W = 12;
  localparam logic [OFF_W-1:0] OFF_REFILL_N = 12'h000;
  localparam logic [OFF_W-1:0] OFF_REFILL_W = 12'h080;
  localparam logic [OFF_W-1:0] OFF_CACHE    = 12'h100;
  localparam logic [OFF_W-1:0] OFF_GENERAL  = 12'h180;
  localparam logic [OFF_W-1:0] OFF_BOOT     = 12'h200;

  localparam logic [31:0] UNCACHED_WIN   = 32'hA000_0000;
  localparam logic [31:0] WIN_FIELD_MASK = 32'h1FFF_F000;

  typedef enum logic [1:0] {
    VK_GENERAL,
    VK_CACHE,
    VK_REFILL_W,
    VK_REFILL_N
  } vec_kind_t;
endpackage

// File: rtl/exc_vec_offset.sv
module exc_vec_offset
  import exc_vec_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              refill,
  input  logic [1:0]        region,
  input  logic              ux,
  input  logic              kx,
  output vec_kind_t         kind,
  output logic [OFF_W-1:0]  offset
);
  logic is_tlb;
  logic wide_ok;

  always_comb begin
    is_tlb  = (code == EC_TLB_LOAD) || (code == EC_TLB_STORE);
    wide_ok = ((region != 2'd0) || ux) && ((region != 2'd3) || kx);
    if (code == EC_CACHE_ERR)  kind = VK_CACHE;
    else if (is_tlb && refill) kind = wide_ok ? VK_REFILL_W : VK_REFILL_N;
    else                       kind = VK_GENERAL;
  end

  always_comb begin
    unique case (kind)
      VK_CACHE:    offset = OFF_CACHE;
      VK_REFILL_W: offset = OFF_REFILL_W;
      VK_REFILL_N: offset = OFF_REFILL_N;
      default:     offset = OFF_GENERAL;
    endcase
  end

  // R5: a refill never lands on anything but the two refill slots
  always_comb begin
    if (refill && is_tlb)
      a_r5_refill_slot: assert (offset == OFF_REFILL_W || offset == OFF_REFILL_N)
        else $error("R5 refill offset %h", offset);
  end
endmodule

// File: rtl/exc_vec_base.sv
module exc_vec_base
  import exc_vec_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int ALIGN_BITS = 12
) (
  input  logic            boot_vec,
  input  logic            cache_err,
  input  logic            segctl_en,
  input  logic            cerr_vec_ovr,
  input  logic [XLEN-1:0] ebase,
  input  logic [XLEN-1:0] boot_base,
  output logic [XLEN-1:0] base
);
  localparam logic [XLEN-1:0] ALIGN_MASK = {XLEN{1'b1}} << ALIGN_BITS;

  logic [XLEN-1:0] win_ext;
  logic [XLEN-1:0] fld_mask;
  logic [XLEN-1:0] boot_vec_base;
  logic            force_win;

  always_comb begin
    win_ext        = {XLEN{UNCACHED_WIN[31]}};
    win_ext[31:0]  = UNCACHED_WIN;
    fld_mask       = '0;
    fld_mask[31:0] = WIN_FIELD_MASK;
    boot_vec_base  = boot_base + {{(XLEN-OFF_W){1'b0}}, OFF_BOOT};
    force_win      = cache_err && !(segctl_en && cerr_vec_ovr);
    if (boot_vec)       base = boot_vec_base;
    else if (force_win) base = win_ext | (ebase & fld_mask);
    else                base = ebase & ALIGN_MASK;
  end

  // R2: outside the boot vector the base is page aligned
  always_comb begin
    if (!boot_vec)
      a_r2_base_aligned: assert (base[ALIGN_BITS-1:0] == '0)
        else $error("R2 base not aligned %h", base);
  end

  // R4: forced cache-error base falls in the uncached window
  always_comb begin
    if (!boot_vec && cache_err && !(segctl_en && cerr_vec_ovr))
      a_r4_uncached_window: assert (base[31:29] == 3'b101)
        else $error("R4 window base %h", base);
  end
endmodule

// File: rtl/exc_vec_cause.sv
module exc_vec_cause
  import exc_vec_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int CAUSE_W  = 32,
  parameter int CODE_LSB = 2
) (
  input  logic               take,
  input  logic               exl,
  input  logic [CODE_W-1:0]  code,
  input  logic [XLEN-1:0]    resume_pc,
  input  logic [CAUSE_W-1:0] cause_in,
  output logic [XLEN-1:0]    epc_next,
  output logic               epc_we,
  output logic [CAUSE_W-1:0] cause_next,
  output logic               set_exl
);
  localparam logic [CAUSE_W-1:0] CODE_MASK =
    {{(CAUSE_W-CODE_W){1'b0}}, {CODE_W{1'b1}}} << CODE_LSB;

  always_comb begin
    cause_next = cause_in;
    cause_next[CODE_LSB +: CODE_W] = code;
    epc_next   = resume_pc;
    epc_we     = take && !exl;
    set_exl    = take;
  end

  // R8: bits outside the code field pass through untouched
  always_comb begin
    a_r8_cause_keep: assert (((cause_next ^ cause_in) & ~CODE_MASK) == '0)
      else $error("R8 cause bits disturbed");
  end

  // R7: nested exception never overwrites EPC
  always_comb begin
    if (exl)
      a_r7_no_epc_nested: assert (!epc_we) else $error("R7 EPC written at EXL");
  end
endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen
  import exc_vec_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int CAUSE_W    = 32,
  parameter int CODE_LSB   = 2,
  parameter int ALIGN_BITS = 12
) (
  input  logic               exc_take,
  input  logic [4:0]         exc_code,
  input  logic               tlb_refill,
  input  logic [XLEN-1:0]    resume_pc,
  input  logic               boot_vec,
  input  logic               exl,
  input  logic [XLEN-1:0]    ebase,
  input  logic [XLEN-1:0]    boot_base,
  input  logic               segctl_en,
  input  logic               cerr_vec_ovr,
  input  logic [1:0]         badva_region,
  input  logic               ux,
  input  logic               kx,
  input  logic [CAUSE_W-1:0] cause_in,
  output logic [XLEN-1:0]    handler_pc,
  output logic [XLEN-1:0]    epc_next,
  output logic               epc_we,
  output logic [CAUSE_W-1:0] cause_next,
  output logic               set_exl
);
  vec_kind_t        kind;
  logic [OFF_W-1:0] offset;
  logic [XLEN-1:0]  base;

  exc_vec_offset u_offset (
    .code   (exc_code),
    .refill (tlb_refill),
    .region (badva_region),
    .ux     (ux),
    .kx     (kx),
    .kind   (kind),
    .offset (offset)
  );

  exc_vec_base #(.XLEN(XLEN), .ALIGN_BITS(ALIGN_BITS)) u_base (
    .boot_vec     (boot_vec),
    .cache_err    (kind == VK_CACHE),
    .segctl_en    (segctl_en),
    .cerr_vec_ovr (cerr_vec_ovr),
    .ebase        (ebase),
    .boot_base    (boot_base),
    .base         (base)
  );

  exc_vec_cause #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .CODE_LSB(CODE_LSB)) u_cause (
    .take       (exc_take),
    .exl        (exl),
    .code       (exc_code),
    .resume_pc  (resume_pc),
    .cause_in   (cause_in),
    .epc_next   (epc_next),
    .epc_we     (epc_we),
    .cause_next (cause_next),
    .set_exl    (set_exl)
  );

  always_comb handler_pc = base + {{(XLEN-OFF_W){1'b0}}, offset};

  // R3: a cache error always enters 0x100 past its base
  always_comb begin
    if (exc_code == EC_CACHE_ERR)
      a_r3_cache_offset: assert (handler_pc - base == {{(XLEN-OFF_W){1'b0}}, OFF_CACHE})
        else $error("R3 cache offset");
  end
endmodule

// File: tb/exc_vec_gen_bench.sv
module exc_vec_gen_bench;
  logic        clk = 1'b0;
  always #5 clk = ~clk;

  logic        exc_take, tlb_refill, boot_vec, exl, segctl_en, cerr_vec_ovr, ux, kx;
  logic [4:0]  exc_code;
  logic [1:0]  badva_region;
  logic [63:0] resume_pc, ebase, boot_base, handler_pc, epc_next;
  logic [31:0] cause_in, cause_next;
  logic        epc_we, set_exl;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  exc_vec_gen u_exc_vec_gen (
    .exc_take(exc_take), .exc_code(exc_code), .tlb_refill(tlb_refill),
    .resume_pc(resume_pc), .boot_vec(boot_vec), .exl(exl), .ebase(ebase),
    .boot_base(boot_base), .segctl_en(segctl_en), .cerr_vec_ovr(cerr_vec_ovr),
    .badva_region(badva_region), .ux(ux), .kx(kx), .cause_in(cause_in),
    .handler_pc(handler_pc), .epc_next(epc_next), .epc_we(epc_we),
    .cause_next(cause_next), .set_exl(set_exl)
  );

  function automatic logic [63:0] exp_off();
    if (exc_code == 5'd30) return 64'h100;
    if (tlb_refill && (exc_code == 5'd2 || exc_code == 5'd3))
      return (((badva_region != 2'd0) || ux) && ((badva_region != 2'd3) || kx))
             ? 64'h080 : 64'h000;
    return 64'h180;
  endfunction

  function automatic logic [63:0] exp_base();
    if (boot_vec) return boot_base + 64'h200;
    if (exc_code == 5'd30 && !(segctl_en && cerr_vec_ovr))
      return 64'hFFFF_FFFF_A000_0000 | (ebase & 64'h1FFF_F000);
    return ebase & ~64'hFFF;
  endfunction

  function automatic string pc_tag();
    if (boot_vec) return "R1";
    if (exc_code == 5'd30) return (segctl_en && cerr_vec_ovr) ? "R3" : "R4";
    if (tlb_refill && (exc_code == 5'd2 || exc_code == 5'd3)) return "R5";
    return "R6";
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    logic [31:0] cexp;
    cexp = cause_in;
    cexp[6:2] = exc_code;
    chk(pc_tag(), handler_pc, exp_base() + exp_off());
    chk("R7 epc_we", {63'd0, epc_we}, {63'd0, exc_take && !exl});
    chk("R7 epc_next", epc_next, resume_pc);
    chk(exc_code == 5'd30 ? "R3 cause" : "R8 cause", {32'd0, cause_next}, {32'd0, cexp});
    chk("R9 set_exl", {63'd0, set_exl}, {63'd0, exc_take});
  endtask

  task automatic apply();
    @(negedge clk);
    #1 check_all();
  endtask

  task automatic randomize_inputs();
    int sel;
    sel = $urandom_range(0, 4);
    exc_code     = (sel == 0) ? 5'd30 : (sel == 1) ? 5'd2 : (sel == 2) ? 5'd3 : 5'($urandom);
    exc_take     = ($urandom_range(0, 7) != 0);
    tlb_refill   = 1'($urandom);
    boot_vec     = ($urandom_range(0, 3) == 0);
    exl          = 1'($urandom);
    segctl_en    = 1'($urandom);
    cerr_vec_ovr = 1'($urandom);
    ux           = 1'($urandom);
    kx           = 1'($urandom);
    badva_region = 2'($urandom);
    resume_pc    = {$urandom, $urandom};
    ebase        = {$urandom, $urandom};
    boot_base    = {$urandom, $urandom};
    cause_in     = $urandom;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    exc_take = 0; exc_code = 5'd0; tlb_refill = 0; boot_vec = 0; exl = 0;
    segctl_en = 0; cerr_vec_ovr = 0; ux = 0; kx = 0; badva_region = 2'd0;
    resume_pc = 64'h0000_0000_8000_1234; ebase = 64'hFFFF_FFFF_8000_0ABC;
    boot_base = 64'hFFFF_FFFF_BFC0_0000; cause_in = 32'hDEAD_BEEF;
    // R9: idle state, no writes requested
    @(negedge clk); #1;
    chk("R9 idle epc_we", {63'd0, epc_we}, 64'd0);
    chk("R9 idle set_exl", {63'd0, set_exl}, 64'd0);

    // R6 general exception, R2 aligned base
    exc_take = 1; exc_code = 5'd8; apply();
    chk("R2 general", handler_pc, 64'hFFFF_FFFF_8000_0180);
    // R6: TLB load without refill
    exc_code = 5'd2; tlb_refill = 0; apply();
    // R5: all region / ux / kx corners
    tlb_refill = 1;
    for (int r = 0; r < 4; r++)
      for (int u = 0; u < 2; u++)
        for (int k = 0; k < 2; k++) begin
          badva_region = 2'(r); ux = 1'(u); kx = 1'(k);
          exc_code = (r[0]) ? 5'd3 : 5'd2;
          apply();
        end
    // R4 / R3: cache error with every override combination
    exc_code = 5'd30; ebase = 64'h1234_5678_FFFF_FFFF;
    for (int s = 0; s < 4; s++) begin
      segctl_en = s[0]; cerr_vec_ovr = s[1]; apply();
    end
    segctl_en = 0; cerr_vec_ovr = 0; apply();
    chk("R4 window", handler_pc, 64'hFFFF_FFFF_BFFF_F100);
    // R1 + R3: boot vector cache error
    boot_vec = 1; apply();
    chk("R1 boot cache", handler_pc, 64'hFFFF_FFFF_BFC0_0300);
    // R7: nested exception keeps EPC
    exl = 1; exc_code = 5'd4; apply();
    chk("R7 nested", {63'd0, epc_we}, 64'd0);
    exl = 0; boot_vec = 0;

    for (int i = 0; i < 3000; i++) begin
      randomize_inputs();
      apply();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule